// File: doc/BRIEF.md
# Sparse Operand Pair Packer

This block sits in front of a four-lane vector multiplier in a sparse convolution engine. Each incoming window holds nine activation values and nine weight values, which cover one 3x3 kernel position set. Each value is a signed 8-bit number. Two 9-bit masks come with the window: one marks the activations that are nonzero and the other marks the weights that are nonzero. A multiply is worth issuing only where both marks are set, so the block ANDs the two masks. It then packs the surviving positions into the multiplier lanes, lowest position first, up to four per cycle. Multiplies with a zero operand are therefore never issued.

A window can have more than four matched positions. In that case it takes several cycles to drain, and the input is held off until the last group is issued. Each lane carries the position it came from, so the accumulator downstream can place the product. A per-cycle count of busy lanes is also output for utilisation statistics.

Top module: `zsm_matcher`

## Requirements
- R1: After reset, `inReady` is 1, `laneValid` is 0 and `laneCount` is 0.
- R2: The lanes issued for a window cover exactly the positions where bit i of `inActMask` and bit i of `inWgtMask` are both 1. Each such position is issued once, and no other position is issued.
- R3: In each cycle, the issued positions are the lowest remaining matched positions, and they are assigned in ascending order. Lane 0 gets the lowest position, and a valid lane n has a higher position than lane n-1.
- R4: A valid lane n carries the position index on `laneIdx[4n+3:4n]`, the activation on `laneAct[8n+7:8n]` and the weight on `laneWgt[8n+7:8n]`. Element i of a window is `inAct[8i+7:8i]` / `inWgt[8i+7:8i]`.
- R5: `laneValid` is always filled from lane 0 upwards, with no gaps. `laneCount` equals the number of valid lanes, from 0 to 4.
- R6: When a window has more than four remaining matches, four lanes issue in a cycle and the rest are carried into the next cycle. `inReady` is 0 in every cycle in which matches would still remain after that cycle's issue.
- R7: A window whose mask AND is all zero issues no lanes.
- R8: Lanes that are not valid drive zero on their index, activation and weight fields.
- R9: A window is taken only on a cycle where `inValid` and `inReady` are both 1. A window offered while `inReady` is 0 has no effect on the lanes issued.
- R10: The first lanes of a window are issued in the cycle after it is taken. If a window's last group issues in a cycle, the next window can be taken in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | A window is offered |
| inReady | output | 1 | The block can take a window this cycle |
| inAct | input | 72 | Nine signed 8-bit activations, element i at [8i+7:8i] |
| inWgt | input | 72 | Nine signed 8-bit weights, element i at [8i+7:8i] |
| inActMask | input | 9 | Bit i set when activation i is nonzero |
| inWgtMask | input | 9 | Bit i set when weight i is nonzero |
| laneValid | output | 4 | Per-lane issue flag |
| laneAct | output | 32 | Per-lane activation operand |
| laneWgt | output | 32 | Per-lane weight operand |
| laneIdx | output | 16 | Per-lane source position, 4 bits per lane |
| laneCount | output | 3 | Number of lanes issued this cycle |

## Verification
The mask pairs in the vector table cover several cases: a fully dense window that needs three groups, a window with exactly four matches, and masks that do not overlap at all. They also include matches of five, three and one, spread across scattered positions. Together these cases separate a correct AND from an OR or from a single mask, show whether lane ordering and carry-over are right at the four-lane boundary, and check that the zero-match case stays idle. Directed cases cover two more things: a window offered while the block is draining, which must be ignored, and a short window followed at once by the next one, which shows whether the ready signal allows back-to-back loading.

// File: rtl/zsm_pkg.sv
package zsm_pkg;
  parameter int WIN   = 9;
  parameter int DW    = 8;
  parameter int LANES = 4;

  localparam int IDXW  = $clog2(WIN);
  localparam int CNTW  = $clog2(LANES + 1);
  localparam int LANEW = $clog2(LANES);

  typedef struct packed {
    logic           loadWin;
    logic [WIN-1:0] pendMask;
  } ctlStrb_t;
endpackage

// File: rtl/zsm_ctrl.sv
module zsm_ctrl
  import zsm_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           inValid,
  input  logic [WIN-1:0] actMask,
  input  logic [WIN-1:0] wgtMask,
  input  logic [WIN-1:0] issuedMask,
  output logic           inReady,
  output ctlStrb_t       strb
);
  logic [WIN-1:0] pendMask;
  logic [WIN-1:0] remainMask;

  assign remainMask    = pendMask & ~issuedMask;
  assign inReady       = (remainMask == '0);
  assign strb.loadWin  = inValid && inReady;
  assign strb.pendMask = pendMask;

  always_ff @(posedge clk) begin
    if (!rstN)             pendMask <= '0;
    else if (strb.loadWin) pendMask <= actMask & wgtMask;
    else                   pendMask <= remainMask;
  end

  // R6
  no_growth_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadWin |=> ((pendMask & ~$past(pendMask)) == '0));

  // R9
  hold_while_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!inReady && inValid) |=> (pendMask != '0));
endmodule

// File: rtl/zsm_dpath.sv
module zsm_dpath
  import zsm_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  ctlStrb_t              strb,
  input  logic [WIN*DW-1:0]     inAct,
  input  logic [WIN*DW-1:0]     inWgt,
  output logic [WIN-1:0]        issuedMask,
  output logic [LANES-1:0]      laneValid,
  output logic [LANES*DW-1:0]   laneAct,
  output logic [LANES*DW-1:0]   laneWgt,
  output logic [LANES*IDXW-1:0] laneIdx,
  output logic [CNTW-1:0]       laneCount
);
  logic [DW-1:0]   actReg [WIN];
  logic [DW-1:0]   wgtReg [WIN];
  logic [IDXW-1:0] pickIdx [LANES];

  generate
    for (genvar e = 0; e < WIN; e++) begin : g_elem
      always_ff @(posedge clk) begin
        if (!rstN) begin
          actReg[e] <= '0;
          wgtReg[e] <= '0;
        end else if (strb.loadWin) begin
          actReg[e] <= inAct[e*DW +: DW];
          wgtReg[e] <= inWgt[e*DW +: DW];
        end
      end
    end
  endgenerate

  // Lowest-first priority pick of up to LANES pending positions
  always_comb begin
    logic [CNTW-1:0] cnt;
    cnt        = '0;
    laneValid  = '0;
    issuedMask = '0;
    for (int l = 0; l < LANES; l++) pickIdx[l] = '0;
    for (int i = 0; i < WIN; i++) begin
      if (strb.pendMask[i] && (cnt < CNTW'(LANES))) begin
        pickIdx[cnt[LANEW-1:0]]   = IDXW'(i);
        laneValid[cnt[LANEW-1:0]] = 1'b1;
        issuedMask[i]             = 1'b1;
        cnt                       = cnt + 1'b1;
      end
    end
    laneCount = cnt;
  end

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign laneIdx[l*IDXW +: IDXW] = pickIdx[l];
      assign laneAct[l*DW +: DW] = laneValid[l] ? actReg[pickIdx[l]] : '0;
      assign laneWgt[l*DW +: DW] = laneValid[l] ? wgtReg[pickIdx[l]] : '0;

      // R2
      match_chk: assert property (@(posedge clk) disable iff (!rstN)
        laneValid[l] |-> (pickIdx[l] < IDXW'(WIN)) && strb.pendMask[pickIdx[l]]);

      // R8
      idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
        !laneValid[l] |-> (laneIdx[l*IDXW +: IDXW] == '0) &&
                          (laneAct[l*DW +: DW] == '0) && (laneWgt[l*DW +: DW] == '0));

      if (l > 0) begin : g_ord
        // R3
        order_chk: assert property (@(posedge clk) disable iff (!rstN)
          laneValid[l] |-> laneValid[l-1] && (pickIdx[l] > pickIdx[l-1]));
      end
    end
  endgenerate

  // R5
  thermo_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({1'b0, laneValid} + 1'b1));

  // R5
  count_chk: assert property (@(posedge clk) disable iff (!rstN)
    laneCount == CNTW'($countones(laneValid)));

  // R7
  empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pendMask == '0) |-> (laneValid == '0));
endmodule

// File: rtl/zsm_matcher.sv
module zsm_matcher
  import zsm_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  output logic                  inReady,
  input  logic [WIN*DW-1:0]     inAct,
  input  logic [WIN*DW-1:0]     inWgt,
  input  logic [WIN-1:0]        inActMask,
  input  logic [WIN-1:0]        inWgtMask,
  output logic [LANES-1:0]      laneValid,
  output logic [LANES*DW-1:0]   laneAct,
  output logic [LANES*DW-1:0]   laneWgt,
  output logic [LANES*IDXW-1:0] laneIdx,
  output logic [CNTW-1:0]       laneCount
);
  ctlStrb_t       strb;
  logic [WIN-1:0] issuedMask;

  zsm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .actMask(inActMask), .wgtMask(inWgtMask),
    .issuedMask(issuedMask), .inReady(inReady), .strb(strb)
  );

  zsm_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .inAct(inAct), .inWgt(inWgt), .issuedMask(issuedMask),
    .laneValid(laneValid), .laneAct(laneAct), .laneWgt(laneWgt),
    .laneIdx(laneIdx), .laneCount(laneCount)
  );

  // R10
  first_issue_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && ((inActMask & inWgtMask) != '0)) |=> (laneValid[0] == 1'b1));
endmodule

// File: tb/zsm_matcher_tb.sv
module zsm_matcher_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [71:0] inAct = '0;
  logic [71:0] inWgt = '0;
  logic [8:0]  inActMask = '0;
  logic [8:0]  inWgtMask = '0;
  logic [3:0]  laneValid;
  logic [31:0] laneAct;
  logic [31:0] laneWgt;
  logic [15:0] laneIdx;
  logic [2:0]  laneCount;

  int checks = 0;
  int failures = 0;
  logic [7:0] curAct [9];
  logic [7:0] curWgt [9];

  always #2 clk = ~clk;

  zsm_matcher dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inAct(inAct), .inWgt(inWgt), .inActMask(inActMask), .inWgtMask(inWgtMask),
    .laneValid(laneValid), .laneAct(laneAct), .laneWgt(laneWgt),
    .laneIdx(laneIdx), .laneCount(laneCount)
  );

  // {activation mask, weight mask, expected match count}
  localparam logic [21:0] VEC [8] = '{
    {9'h1FF, 9'h1FF, 4'd9},
    {9'h0AA, 9'h0FF, 4'd4},
    {9'h155, 9'h0AA, 4'd0},
    {9'h1F0, 9'h13C, 4'd3},
    {9'h100, 9'h1FF, 4'd1},
    {9'h0F3, 9'h1DF, 4'd5},
    {9'h1B6, 9'h17E, 4'd5},
    {9'h001, 9'h001, 4'd1}
  };

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic setWindow(input logic [8:0] am, input logic [8:0] wm, input int seed);
    for (int i = 0; i < 9; i++) begin
      curAct[i] = 8'(i * 29 + seed * 13 + 5);
      curWgt[i] = 8'((i * 71 + seed * 7) ^ 8'h5A);
      inAct[i*8 +: 8] = curAct[i];
      inWgt[i*8 +: 8] = curWgt[i];
    end
    inActMask = am;
    inWgtMask = wm;
  endtask

  task automatic checkIdle(input string req);
    check(laneValid == 4'b0 && laneCount == 3'd0, req, laneValid, 0);
    check(laneIdx == '0 && laneAct == '0 && laneWgt == '0, {req, "/R8"}, laneAct, 0);
  endtask

  task automatic checkChunk(inout logic [8:0] rem, inout int total);
    logic [3:0] expIdx [4];
    logic [3:0] expVld;
    int k;
    k = 0;
    expVld = '0;
    for (int l = 0; l < 4; l++) expIdx[l] = '0;
    for (int i = 0; i < 9; i++) begin
      if (rem[i] && k < 4) begin
        expIdx[k] = 4'(i);
        expVld[k] = 1'b1;
        rem[i] = 1'b0;
        k++;
      end
    end
    check(laneValid == expVld, "R5 lane valid", laneValid, expVld);
    check(int'(laneCount) == k, "R5 lane count", laneCount, k);
    for (int l = 0; l < 4; l++) begin
      if (expVld[l]) begin
        check(laneIdx[l*4 +: 4] == expIdx[l], "R3 lane index", laneIdx[l*4 +: 4], expIdx[l]);
        check(laneAct[l*8 +: 8] == curAct[expIdx[l]], "R4 lane act",
              laneAct[l*8 +: 8], curAct[expIdx[l]]);
        check(laneWgt[l*8 +: 8] == curWgt[expIdx[l]], "R4 lane wgt",
              laneWgt[l*8 +: 8], curWgt[expIdx[l]]);
      end else begin
        check(laneIdx[l*4 +: 4] == 0 && laneAct[l*8 +: 8] == 0, "R8 idle lane",
              laneAct[l*8 +: 8], 0);
      end
    end
    check(inReady == (rem == 0), "R6 ready during drain", inReady, rem == 0);
    total += int'(laneCount);
  endtask

  task automatic runWindow(input logic [8:0] am, input logic [8:0] wm, input int expN,
                           input int seed, input bit intrude);
    logic [8:0] rem;
    int total;
    bit first;
    setWindow(am, wm, seed);
    inValid = 1'b1;
    check(inReady == 1'b1, "R10 ready when idle", inReady, 1);
    @(negedge clk);
    inValid = 1'b0;
    rem = am & wm;
    total = 0;
    first = 1'b1;
    while (rem != 0) begin
      checkChunk(rem, total);
      if (intrude && first) begin
        inActMask = 9'h003;
        inWgtMask = 9'h003;
        inAct = ~inAct;
        inValid = 1'b1;
      end
      first = 1'b0;
      @(negedge clk);
      inValid = 1'b0;
    end
    check(total == expN, "R2 total issued", total, expN);
    checkIdle(expN == 0 ? "R7 no-match idle" : "R9 idle after drain");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [8:0] rem;
    int total;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check(inReady == 1'b1, "R1 ready", inReady, 1);
    check(laneValid == 0 && laneCount == 0, "R1 lanes", laneValid, 0);

    for (int v = 0; v < 8; v++)
      runWindow(VEC[v][21:13], VEC[v][12:4], int'(VEC[v][3:0]), v, 1'b0);

    // R9: window offered while draining must be ignored
    runWindow(9'h1FF, 9'h1FF, 9, 20, 1'b1);

    // R10: back-to-back windows
    setWindow(9'h007, 9'h00F, 30);
    inValid = 1'b1;
    @(negedge clk);
    rem = 9'h007;
    total = 0;
    checkChunk(rem, total);
    setWindow(9'h1C0, 9'h1E0, 31);
    check(inReady == 1'b1, "R10 back-to-back ready", inReady, 1);
    @(negedge clk);
    inValid = 1'b0;
    rem = 9'h1C0;
    checkChunk(rem, total);
    check(total == 6, "R10 both windows issued", total, 6);
    @(negedge clk);
    checkIdle("R10 idle");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule